// File: doc/BRIEF.md
# Tagged Sample Buffer with Level Interrupt

This block buffers the results of a sampling converter until a processor collects them. Each incoming sample is a 16-bit value with a 4-bit channel number. Samples are stored in arrival order in a 64-entry buffer. The processor reaches the buffer through a small register port. Reading the data register removes the oldest sample. Software can also read the number of occupied entries and program a fill level.

When the occupancy first reaches the programmed level, a level event occurs. Depending on configuration, that event either latches an interrupt request or produces a one-cycle pulse on a separate trigger output. Three causes can request an interrupt: level, overflow and underflow. Each has a request bit that stays latched until it is cleared. Software can also force any request bit through a set register and enable each cause through a mask. The interrupt line is the OR of the request bits that are enabled. An optional mode clears the level request automatically whenever the data register is read.

Top module: `tsb_top`

## Requirements
- R1: Each read of the data register (address 0 with `reg_re_i`) returns the oldest stored sample and removes it. Samples come out in the order they were written.
- R2: The count register (address 1) returns the number of occupied entries. It is 0 after reset. On a cycle with both an accepted write and a read, the count is unchanged.
- R3: The config register is at address 2: level in bits 8:0, tag enable in bit 9, clear-on-read in bit 10, trigger-output select in bit 11. After reset the level is 1 and the three mode bits are 0. When the occupancy goes from below the level to at or above it, request bit 0 is set on the next clock edge. This happens only if trigger-output select is 0.
- R4: The buffer holds 64 samples. A sample presented while the buffer is full is dropped, and request bit 1 (overflow) is set.
- R5: The data word carries the sample value in bits 15:0 and the channel number in bits 19:16. All other bits are 0. Bits 19:16 read as 0 when tag enable is 0.
- R6: The request register (address 3) holds bit 0 level, bit 1 overflow and bit 2 underflow. A set bit stays set until software writes a 1 to it at address 3. Bit 0 is not set again while the occupancy stays at or above the level.
- R7: Writing a mask to the set register (address 4) sets the corresponding request bits. Address 4 reads as 0.
- R8: The mask register (address 5) is readable and writable. Address 6 reads as the bitwise AND of request and mask. `irq_o` is high exactly when that AND is nonzero.
- R9: When clear-on-read is 1, every data read clears request bit 0.
- R10: When trigger-output select is 1, a level event raises `trig_o` for exactly one cycle instead of setting request bit 0.
- R11: A data read while the buffer is empty returns 0, leaves the count at 0, and sets request bit 2 (underflow).
- R12: If a cause sets a request bit in the same cycle that a clear targets that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample write strobe |
| smp_value_i | input | 16 | Sample value |
| smp_chan_i | input | 4 | Channel number of the sample |
| reg_re_i | input | 1 | Register read strobe (pops at address 0) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the addressed register |
| irq_o | output | 1 | Interrupt: OR of masked request bits |
| trig_o | output | 1 | One-cycle level trigger pulse |

## Verification
The bench fills the buffer to 64 entries and pushes past full in the same cycle that software clears the overflow bit. A design that lets the clear win, or accepts the extra sample, will show a wrong count or a missing bit 1. It then drains past empty, where a design that wraps its pointers returns a stale sample instead of 0.

The level event is exercised in several ways. The fill crosses the level, software clears the bit while the occupancy stays high, and the level is changed on the fly. A design that treats the level as a state rather than a crossing re-raises bit 0 right after the clear. Trigger-output mode must pulse for a single cycle and leave bit 0 alone. Clear-on-read must drop bit 0 on the read itself.

Random traffic mixes simultaneous writes and reads, mask and set writes, and reads with tagging toggled. Every register readback, `irq_o` and `trig_o` is compared in every cycle.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NCAUSE = 3;

  localparam logic [ADDR_W-1:0] A_DATA   = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CFG    = 3'd2;
  localparam logic [ADDR_W-1:0] A_REQ    = 3'd3;
  localparam logic [ADDR_W-1:0] A_SET    = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd5;
  localparam logic [ADDR_W-1:0] A_MASKED = 3'd6;

  localparam int unsigned C_LEVEL = 0;
  localparam int unsigned C_OVF   = 1;
  localparam int unsigned C_UNF   = 2;
endpackage

// File: rtl/tsb_store.sv
module tsb_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 20,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R4
  depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R2
  cnt_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok && !pop_ok) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/tsb_irq.sv
module tsb_irq #(
  parameter int unsigned NC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NC-1:0] hw_set_i,
  input  logic [NC-1:0] sw_set_i,
  input  logic [NC-1:0] clr_i,
  input  logic          mask_we_i,
  input  logic [NC-1:0] mask_wdata_i,
  output logic [NC-1:0] req_o,
  output logic [NC-1:0] mask_o,
  output logic [NC-1:0] masked_o,
  output logic          irq_o
);
  logic [NC-1:0] req_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      mask_q <= '0;
    end else begin
      req_q <= (req_q & ~clr_i) | hw_set_i | sw_set_i;  // set wins
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign req_o    = req_q;
  assign mask_o   = mask_q;
  assign masked_o = req_q & mask_q;
  assign irq_o    = |masked_o;

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((req_q & $past(req_q & ~clr_i)) == $past(req_q & ~clr_i)));
  // R12
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(hw_set_i & clr_i)) |=> ((req_q & $past(hw_set_i & clr_i)) == $past(hw_set_i & clr_i)));
endmodule

// File: rtl/tsb_top.sv
module tsb_top
  import tsb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned VAL_W = 16,
  parameter int unsigned TAG_W = 4,
  parameter int unsigned LVL_W = 9,
  localparam int unsigned ENT_W = VAL_W + TAG_W,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [VAL_W-1:0] smp_value_i,
  input  logic [TAG_W-1:0] smp_chan_i,
  input  logic             reg_re_i,
  input  logic             reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             irq_o,
  output logic             trig_o
);
  logic [LVL_W-1:0]  lvl_q;
  logic              tag_en_q, clr_rd_q, trig_sel_q, hit_q;
  logic              rd_data, hit, rise, full, empty;
  logic [ENT_W-1:0]  head;
  logic [CNT_W-1:0]  count;
  logic [NCAUSE-1:0] hw_set, sw_set, clr, req, mask, masked;

  assign rd_data = reg_re_i && (reg_addr_i == A_DATA);

  tsb_store #(.DEPTH(DEPTH), .W(ENT_W)) u_store (
    .clk_i, .rst_ni,
    .push_i  (smp_valid_i),
    .pop_i   (rd_data),
    .wdata_i ({smp_chan_i, smp_value_i}),
    .head_o  (head),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q      <= LVL_W'(1);
      tag_en_q   <= 1'b0;
      clr_rd_q   <= 1'b0;
      trig_sel_q <= 1'b0;
      hit_q      <= 1'b0;
    end else begin
      hit_q <= hit;
      if (reg_we_i && reg_addr_i == A_CFG) begin
        lvl_q      <= reg_wdata_i[LVL_W-1:0];
        tag_en_q   <= reg_wdata_i[LVL_W];
        clr_rd_q   <= reg_wdata_i[LVL_W+1];
        trig_sel_q <= reg_wdata_i[LVL_W+2];
      end
    end
  end

  assign hit  = LVL_W'(count) >= lvl_q;
  assign rise = hit & ~hit_q;

  always_comb begin
    hw_set          = '0;
    hw_set[C_LEVEL] = rise & ~trig_sel_q;
    hw_set[C_OVF]   = smp_valid_i & full;
    hw_set[C_UNF]   = rd_data & empty;
    sw_set = (reg_we_i && reg_addr_i == A_SET) ? reg_wdata_i[NCAUSE-1:0] : '0;
    clr    = (reg_we_i && reg_addr_i == A_REQ) ? reg_wdata_i[NCAUSE-1:0] : '0;
    clr[C_LEVEL] = clr[C_LEVEL] | (clr_rd_q & rd_data);
  end

  tsb_irq #(.NC(NCAUSE)) u_irq (
    .clk_i, .rst_ni,
    .hw_set_i     (hw_set),
    .sw_set_i     (sw_set),
    .clr_i        (clr),
    .mask_we_i    (reg_we_i && reg_addr_i == A_MASK),
    .mask_wdata_i (reg_wdata_i[NCAUSE-1:0]),
    .req_o        (req),
    .mask_o       (mask),
    .masked_o     (masked),
    .irq_o        (irq_o)
  );

  assign trig_o = trig_sel_q & rise;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_DATA: if (!empty) begin
        reg_rdata_o[VAL_W-1:0] = head[VAL_W-1:0];
        if (tag_en_q) reg_rdata_o[VAL_W+:TAG_W] = head[VAL_W+:TAG_W];
      end
      A_COUNT:  reg_rdata_o[CNT_W-1:0] = count;
      A_CFG:    reg_rdata_o[LVL_W+2:0] = {trig_sel_q, clr_rd_q, tag_en_q, lvl_q};
      A_REQ:    reg_rdata_o[NCAUSE-1:0] = req;
      A_MASK:   reg_rdata_o[NCAUSE-1:0] = mask;
      A_MASKED: reg_rdata_o[NCAUSE-1:0] = masked;
      default:  reg_rdata_o = '0;
    endcase
  end

  // R10
  trig_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
  // R11
  underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && empty) |=> req[C_UNF]);
endmodule

// File: tb/tsb_top_tb_top.sv
`timescale 1ns/1ps
module tsb_top_tb_top;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_value = '0;
  logic [3:0]  smp_chan = '0;
  logic        reg_re = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, trig;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tsb_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .smp_valid_i(smp_valid), .smp_value_i(smp_value), .smp_chan_i(smp_chan),
    .reg_re_i(reg_re), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq), .trig_o(trig)
  );

  // reference model state
  logic [19:0] q[$];
  logic [8:0]  m_lvl = 9'd1;
  bit          m_tag = 0, m_cor = 0, m_tsel = 0, m_hitq = 0;
  logic [2:0]  m_req = '0, m_mask = '0;

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    logic [31:0] r = '0;
    case (a)
      3'd0: if (q.size() > 0) begin
        r[15:0] = q[0][15:0];
        if (m_tag) r[19:16] = q[0][19:16];
      end
      3'd1: r = 32'(q.size());
      3'd2: r = {20'd0, m_tsel, m_cor, m_tag, m_lvl};
      3'd3: r = {29'd0, m_req};
      3'd5: r = {29'd0, m_mask};
      3'd6: r = {29'd0, m_req & m_mask};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string addr_req(input logic [2:0] a);
    case (a)
      3'd0: return "R1/R5";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input string ctx, input bit psh, input logic [15:0] v,
                      input logic [3:0] ch, input bit re, input bit we,
                      input logic [2:0] a, input logic [31:0] wd);
    bit hit, rise, pop, full;
    logic [2:0] set, clr;
    @(negedge clk);
    smp_valid = psh; smp_value = v; smp_chan = ch;
    reg_re = re; reg_we = we; reg_addr = a; reg_wdata = wd;
    #1;
    hit  = ({23'd0, q.size()} >= {23'd0, m_lvl}) ;
    rise = hit && !m_hitq;
    chk({ctx, " ", addr_req(a), " rdata"}, reg_rdata, exp_rd(a));
    chk({ctx, " R8 irq"}, {31'd0, irq}, {31'd0, |(m_req & m_mask)});
    chk({ctx, " R10 trig"}, {31'd0, trig}, {31'd0, m_tsel && rise});
    @(posedge clk);
    pop  = re && a == 3'd0;
    full = q.size() == DEPTH;
    set  = {pop && q.size() == 0, psh && full, rise && !m_tsel};
    if (we && a == 3'd4) set |= wd[2:0];
    clr  = (we && a == 3'd3) ? wd[2:0] : 3'd0;
    if (m_cor && pop) clr[0] = 1'b1;
    m_req  = (m_req & ~clr) | set;
    m_hitq = hit;
    if (pop && q.size() > 0) void'(q.pop_front());
    if (psh && !full) q.push_back({ch, v});
    if (we && a == 3'd2) begin
      m_lvl = wd[8:0]; m_tag = wd[9]; m_cor = wd[10]; m_tsel = wd[11];
    end
    if (we && a == 3'd5) m_mask = wd[2:0];
  endtask

  task automatic idle(input string ctx, input logic [2:0] a);
    step(ctx, 0, 16'h0, 4'h0, 0, 0, a, 32'h0);
  endtask
  task automatic wr(input string ctx, input logic [2:0] a, input logic [31:0] d);
    step(ctx, 0, 16'h0, 4'h0, 0, 1, a, d);
  endtask
  task automatic push(input string ctx, input logic [15:0] v, input logic [3:0] c, input logic [2:0] a);
    step(ctx, 1, v, c, 0, 0, a, 32'h0);
  endtask
  task automatic pop(input string ctx);
    step(ctx, 0, 16'h0, 4'h0, 1, 0, 3'd0, 32'h0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5A17_0C3E));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state R2 R3 R6
    idle("reset R2", 3'd1);
    idle("reset R3", 3'd2);
    idle("reset R6", 3'd3);
    wr("R8 mask", 3'd5, 32'h7);
    wr("R6 clr", 3'd3, 32'h7);
    // R1 R5 order and tag
    wr("R5 cfg", 3'd2, {20'd0, 3'b001, 9'd40});
    for (int i = 0; i < 5; i++) push("R1 fill", 16'hA000 + 16'(i), 4'(i + 9), 3'd1);
    for (int i = 0; i < 3; i++) pop("R1 R5 tagged");
    wr("R5 untag", 3'd2, {20'd0, 3'b000, 9'd40});
    pop("R5 untagged");
    pop("R5 untagged");
    idle("R2 empty", 3'd1);
    // R3 level crossing, R6 hold after clear
    wr("R3 cfg", 3'd2, {20'd0, 3'b001, 9'd4});
    for (int i = 0; i < 5; i++) push("R3 fill", 16'h1200 + 16'(i), 4'(i), 3'd3);
    idle("R3 req", 3'd3);
    wr("R6 w1c", 3'd3, 32'h1);
    idle("R6 no reraise", 3'd3);
    push("R6 still above", 16'h5555, 4'h5, 3'd3);
    // R7 software set and R8 masked view
    wr("R7 set", 3'd4, 32'h6);
    idle("R7 req", 3'd3);
    idle("R7 reads zero", 3'd4);
    wr("R8 mask", 3'd5, 32'h2);
    idle("R8 masked", 3'd6);
    wr("R8 mask0", 3'd5, 32'h0);
    idle("R8 no irq", 3'd6);
    wr("R6 clr", 3'd3, 32'h7);
    wr("R8 mask", 3'd5, 32'h1);
    // R9 clear-on-read
    while (q.size() > 0) pop("R9 drain");
    wr("R9 cfg", 3'd2, {20'd0, 3'b011, 9'd2});
    wr("R6 clr", 3'd3, 32'h7);
    push("R9 a", 16'h0909, 4'h1, 3'd3);
    push("R9 b", 16'h0A0A, 4'h2, 3'd3);
    idle("R9 set", 3'd3);
    push("R9 c", 16'h0B0B, 4'h3, 3'd3);
    pop("R9 read clears");
    idle("R9 cleared", 3'd3);
    // R10 trigger output
    while (q.size() > 0) pop("R10 drain");
    wr("R10 cfg", 3'd2, {20'd0, 3'b101, 9'd3});
    wr("R6 clr", 3'd3, 32'h7);
    for (int i = 0; i < 5; i++) push("R10 fill", 16'h0C00 + 16'(i), 4'h7, 3'd3);
    idle("R10 no req", 3'd3);
    // R4 overflow with R12 concurrent clear
    wr("R4 cfg", 3'd2, {20'd0, 3'b001, 9'd64});
    wr("R8 mask", 3'd5, 32'h7);
    while (q.size() < DEPTH) push("R4 fill", 16'($urandom), 4'($urandom), 3'd1);
    idle("R4 full count", 3'd1);
    step("R12 ovf vs clr", 1, 16'hDEAD, 4'hD, 0, 1, 3'd3, 32'h2);
    idle("R4 R12 req", 3'd3);
    push("R4 dropped", 16'hBEEF, 4'hE, 3'd1);
    idle("R4 count", 3'd1);
    // R11 underflow
    wr("R6 clr", 3'd3, 32'h7);
    while (q.size() > 0) pop("R1 drain");
    pop("R11 empty read");
    idle("R11 req", 3'd3);
    idle("R11 count", 3'd1);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 100);
      bit p = ($urandom % 2) == 1;
      logic [15:0] v = 16'($urandom);
      logic [3:0] c = 4'($urandom);
      if (r < 40)      step("rnd R1", p, v, c, 1, 0, 3'd0, 32'h0);
      else if (r < 60) step("rnd", p, v, c, 1, 0, 3'($urandom % 8), 32'h0);
      else if (r < 65) step("rnd R3", p, v, c, 0, 1, 3'd2,
                            {20'd0, 3'($urandom), 9'(1 + $urandom % 70)});
      else if (r < 72) step("rnd R8", p, v, c, 0, 1, 3'd5, 32'($urandom));
      else if (r < 80) step("rnd R6", p, v, c, 0, 1, 3'd3, 32'($urandom));
      else if (r < 83) step("rnd R7", p, v, c, 0, 1, 3'd4, 32'($urandom));
      else             step("rnd", p, v, c, 0, 0, 3'($urandom % 8), 32'h0);
    end
    summary();
  end
endmodule